// File: doc/BRIEF.md
# Serial Frame Start Condition Detector

This block decides the cycle in which a synchronous serial channel, receive or transmit, begins a frame. A 4-bit mode code picks one start condition. The conditions are:

- continuous framing;
- the opposite channel's own start strobe;
- a low or high level on the frame-sync line;
- a falling or rising edge on that line;
- a change against the level seen at the last start;
- any edge between consecutive samples;
- a received-data compare match.

The frame-sync line passes through a two-stage synchronizer. Level and edge tests are made only on cycles where the bit-clock enable is high.

Once a start is accepted, the block counts a programmable number of bit periods, then releases the first data bit. It raises a one-cycle start pulse and a frame-active level, which holds until the data path reports the end of the frame.

A separate period counter produces a tick every 2*(P+1) bit periods. Logic that drives the frame-sync line itself can use this tick as its frame period. Bit clock generation and data shifting live outside this block.

Top module: `frame_start_unit`

## Requirements
- R1: After reset, `startPulse`, `frameActive` and `periodTick` are 0 and the channel is disabled.
- R2: Mode 0 (continuous) with delay 0 starts two cycles after `enableReq`, and a `frameEnd` strobe starts the next frame back to back in the following cycle without dropping `frameActive`.
- R3: Mode 1 starts in the cycle after a `peerStart` strobe.
- R4: Mode 2 starts while the synchronized line is low and mode 3 while it is high, both on `bitEn` cycles.
- R5: Mode 4 starts on a falling edge and mode 5 on a rising edge of the line, three cycles after the input change (two synchronizer stages plus the state register); the opposite edge is ignored.
- R6: Mode 6 starts when the line differs from the level captured at enable or at the last start, so a change made during a frame starts the next frame when it ends; mode 7 starts only on an edge between consecutive samples, so such a change is lost.
- R7: Mode 8 starts in the cycle after a `cmpMatch` strobe and ignores `peerStart`.
- R8: With a nonzero `startDelay` D, the start pulse comes D `bitEn` periods later than with D = 0.
- R9: Outside mode 0, a start condition seen while a frame is active is ignored, and `frameActive` stays high until `frameEnd`.
- R10: Mode codes 9 to 15 never start a frame.
- R11: `disableReq` returns the block to disabled within one cycle and cancels any delay in progress. It wins over a simultaneous `enableReq`. While disabled, all start conditions are ignored.
- R12: When `periodSel` P is nonzero and the channel is enabled, `periodTick` pulses every 2*(P+1) `bitEn` cycles, first 4*(P+1)/2+1 = 2P+3 cycles after `enableReq`; with P = 0 it never pulses.
- R13: `startPulse` lasts one cycle and comes together with the rise of `frameActive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-clock enable, one cycle per bit period |
| enableReq | input | 1 | Enable strobe |
| disableReq | input | 1 | Disable strobe, dominant |
| startMode | input | 4 | Start condition code 0..15 |
| startDelay | input | 8 | Bit periods from accepted start to first data bit |
| periodSel | input | 8 | Internal frame period selector, 0 = off |
| syncIn | input | 1 | Asynchronous frame-sync line |
| peerStart | input | 1 | Opposite channel start strobe |
| cmpMatch | input | 1 | Received-data compare match strobe |
| frameEnd | input | 1 | End of current frame strobe from the data path |
| startPulse | output | 1 | One-cycle pulse when the first data bit is released |
| frameActive | output | 1 | High while a frame is in progress |
| periodTick | output | 1 | One-cycle internal frame period tick |

## Verification
Some properties can be checked on every cycle:

- a start pulse always comes with the rise of frame-active;
- an active frame persists until the end strobe or a disable;
- a disable clears the outputs one cycle later;
- unused mode codes never produce a trigger;
- a zero period selector never produces a tick.

Other behaviour can only be shown by the bench's scenarios. These are the exact start cycles of each mode, including synchronizer latency and the start delay. They also include the difference between level-change and edge modes when the line moves during a frame, the cancelling of a pending delayed start, and the tick spacing of the period counter.

// File: rtl/frame_start_pkg.sv
package frame_start_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_DELAY  = 2'd2,
    ST_ACTIVE = 2'd3
  } fsState_t;

  // Strobes from the control FSM into the datapath
  typedef struct packed {
    logic loadDelay;   // load the start-delay counter
    logic captureRef;  // capture the reference level of the sync line
    logic clearDelay;  // drop any delay in progress
    logic runPeriod;   // channel enabled: period counter may run
  } ctlStrobe_t;

  // Start condition codes
  localparam int MD_CONT    = 0;
  localparam int MD_PEER    = 1;
  localparam int MD_LOW     = 2;
  localparam int MD_HIGH    = 3;
  localparam int MD_FALL    = 4;
  localparam int MD_RISE    = 5;
  localparam int MD_CHANGE  = 6;
  localparam int MD_EDGE    = 7;
  localparam int MD_COMPARE = 8;

endpackage

// File: rtl/fs_datapath.sv
module fs_datapath
  import frame_start_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int DLY_W       = 8,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              syncIn,
  input  logic              peerStart,
  input  logic              cmpMatch,
  input  logic [MODE_W-1:0] startMode,
  input  logic [DLY_W-1:0]  startDelay,
  input  logic [PER_W-1:0]  periodSel,
  input  ctlStrobe_t        strobe,
  output logic              trigHit,
  output logic              delayZero,
  output logic              delayLast,
  output logic              periodTick
);

  localparam int CNT_W = PER_W + 1;

  // ---------------- frame-sync synchronizer ----------------
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncNow;
  logic syncPrev;
  logic refLevel;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= syncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= syncChain[g-1];
      end
    end
  end

  assign syncNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      refLevel <= 1'b0;
    end else begin
      if (bitEn)             syncPrev <= syncNow;
      if (strobe.captureRef) refLevel <= syncNow;
    end
  end

  // ---------------- start condition select ----------------
  logic levelChg;
  logic edgeAny;
  assign levelChg = syncNow ^ refLevel;
  assign edgeAny  = syncNow ^ syncPrev;

  always_comb begin
    case (startMode)
      MODE_W'(MD_CONT):    trigHit = 1'b1;
      MODE_W'(MD_PEER):    trigHit = peerStart;
      MODE_W'(MD_LOW):     trigHit = bitEn & ~syncNow;
      MODE_W'(MD_HIGH):    trigHit = bitEn & syncNow;
      MODE_W'(MD_FALL):    trigHit = bitEn & syncPrev & ~syncNow;
      MODE_W'(MD_RISE):    trigHit = bitEn & ~syncPrev & syncNow;
      MODE_W'(MD_CHANGE):  trigHit = bitEn & levelChg;
      MODE_W'(MD_EDGE):    trigHit = bitEn & edgeAny;
      MODE_W'(MD_COMPARE): trigHit = cmpMatch;
      default:             trigHit = 1'b0;
    endcase
  end

  // ---------------- start delay counter ----------------
  logic [DLY_W-1:0] delayCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                          delayCnt <= '0;
    else if (strobe.clearDelay)         delayCnt <= '0;
    else if (strobe.loadDelay)          delayCnt <= startDelay;
    else if (bitEn && delayCnt != '0)   delayCnt <= delayCnt - 1'b1;
  end

  assign delayZero = (startDelay == '0);
  assign delayLast = bitEn && (delayCnt == DLY_W'(1));

  // ---------------- internal frame period ----------------
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] perLast;
  assign perLast = {periodSel, 1'b1};  // 2*(P+1) - 1

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perCnt     <= '0;
      periodTick <= 1'b0;
    end else begin
      periodTick <= 1'b0;
      if (!strobe.runPeriod || periodSel == '0) begin
        perCnt <= '0;
      end else if (bitEn) begin
        if (perCnt >= perLast) begin
          perCnt     <= '0;
          periodTick <= 1'b1;
        end else begin
          perCnt <= perCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fs_control.sv
module fs_control
  import frame_start_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableReq,
  input  logic       disableReq,
  input  logic       frameEnd,
  input  logic       isCont,
  input  logic       trigHit,
  input  logic       delayZero,
  input  logic       delayLast,
  output ctlStrobe_t strobe,
  output logic       startPulse,
  output logic       frameActive
);

  fsState_t state, nextState;
  logic goPulse;

  always_comb begin
    nextState = state;
    strobe    = '0;
    goPulse   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (enableReq) begin
          nextState         = ST_ARMED;
          strobe.captureRef = 1'b1;
        end
      end
      ST_ARMED: begin
        if (trigHit) begin
          strobe.captureRef = 1'b1;
          if (delayZero) begin
            nextState = ST_ACTIVE;
            goPulse   = 1'b1;
          end else begin
            nextState        = ST_DELAY;
            strobe.loadDelay = 1'b1;
          end
        end
      end
      ST_DELAY: begin
        if (delayLast) begin
          nextState = ST_ACTIVE;
          goPulse   = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (frameEnd) begin
          if (isCont) begin
            strobe.captureRef = 1'b1;
            if (delayZero) begin
              goPulse = 1'b1;
            end else begin
              nextState        = ST_DELAY;
              strobe.loadDelay = 1'b1;
            end
          end else begin
            nextState = ST_ARMED;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (disableReq) begin
      nextState         = ST_IDLE;
      strobe            = '0;
      strobe.clearDelay = 1'b1;
      goPulse           = 1'b0;
    end
    strobe.runPeriod = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      startPulse <= 1'b0;
    end else begin
      state      <= nextState;
      startPulse <= goPulse;
    end
  end

  assign frameActive = (state == ST_ACTIVE);

endmodule

// File: rtl/frame_start_unit.sv
module frame_start_unit
  import frame_start_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int DLY_W       = 8,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              enableReq,
  input  logic              disableReq,
  input  logic [MODE_W-1:0] startMode,
  input  logic [DLY_W-1:0]  startDelay,
  input  logic [PER_W-1:0]  periodSel,
  input  logic              syncIn,
  input  logic              peerStart,
  input  logic              cmpMatch,
  input  logic              frameEnd,
  output logic              startPulse,
  output logic              frameActive,
  output logic              periodTick
);

  ctlStrobe_t strobe;
  logic trigHit;
  logic delayZero;
  logic delayLast;
  logic isCont;

  assign isCont = (startMode == MODE_W'(MD_CONT));

  fs_datapath #(
    .MODE_W(MODE_W), .DLY_W(DLY_W), .PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .syncIn(syncIn),
    .peerStart(peerStart), .cmpMatch(cmpMatch), .startMode(startMode),
    .startDelay(startDelay), .periodSel(periodSel), .strobe(strobe),
    .trigHit(trigHit), .delayZero(delayZero), .delayLast(delayLast),
    .periodTick(periodTick)
  );

  fs_control ctl_i (
    .clk(clk), .rstN(rstN), .enableReq(enableReq), .disableReq(disableReq),
    .frameEnd(frameEnd), .isCont(isCont), .trigHit(trigHit),
    .delayZero(delayZero), .delayLast(delayLast), .strobe(strobe),
    .startPulse(startPulse), .frameActive(frameActive)
  );

endmodule

// File: rtl/frame_start_unit_chk.sv
module frame_start_unit_chk #(
  parameter int MODE_W = 4,
  parameter int PER_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] startMode,
  input logic [PER_W-1:0]  periodSel,
  input logic              disableReq,
  input logic              frameEnd,
  input logic              startPulse,
  input logic              frameActive,
  input logic              periodTick,
  input logic              trigHit
);

  // R13
  pulse_with_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameActive) |-> startPulse);

  // R13
  pulse_needs_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> frameActive);

  // R9
  active_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && !frameEnd && !disableReq) |=> frameActive);

  // R11
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    disableReq |=> (!frameActive && !startPulse));

  // R10
  unused_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startMode >= MODE_W'(9)) |-> !trigHit);

  // R12
  no_period_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(periodSel) == '0) |-> !periodTick);

endmodule

bind frame_start_unit frame_start_unit_chk #(.MODE_W(MODE_W), .PER_W(PER_W)) chk_i (
  .clk(clk), .rstN(rstN), .startMode(startMode), .periodSel(periodSel),
  .disableReq(disableReq), .frameEnd(frameEnd), .startPulse(startPulse),
  .frameActive(frameActive), .periodTick(periodTick), .trigHit(trigHit)
);

// File: tb/frame_start_unit_tb_top.sv
module frame_start_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b1;
  logic       enableReq = 1'b0;
  logic       disableReq = 1'b0;
  logic [3:0] startMode = 4'd9;
  logic [7:0] startDelay = 8'd0;
  logic [7:0] periodSel = 8'd0;
  logic       syncIn = 1'b0;
  logic       peerStart = 1'b0;
  logic       cmpMatch = 1'b0;
  logic       frameEnd = 1'b0;
  logic       startPulse;
  logic       frameActive;
  logic       periodTick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int expCyc[$];
  string expTag[$];
  int tickLog[$];

  always #4 clk = ~clk;  // 125 MHz

  frame_start_unit dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .enableReq(enableReq),
    .disableReq(disableReq), .startMode(startMode), .startDelay(startDelay),
    .periodSel(periodSel), .syncIn(syncIn), .peerStart(peerStart),
    .cmpMatch(cmpMatch), .frameEnd(frameEnd), .startPulse(startPulse),
    .frameActive(frameActive), .periodTick(periodTick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Scoreboard monitor: every start pulse must match the head of the queue
  always @(negedge clk) begin
    if (rstN) begin
      if (periodTick) tickLog.push_back(cyc);
      if (startPulse) begin
        check(frameActive == 1'b1, "R13 pulse without frameActive", int'(frameActive), 1);
        if (expCyc.size() == 0) begin
          check(1'b0, "R11 unexpected start pulse", cyc, -1);
        end else begin
          int e;
          string t;
          e = expCyc.pop_front();
          t = expTag.pop_front();
          check(cyc == e, t, cyc, e);
        end
      end
    end
  end

  task automatic expectIn(int d, string tag);
    expCyc.push_back(cyc + d);
    expTag.push_back(tag);
  endtask

  task automatic waitCyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic doEnable();
    enableReq = 1'b1; @(negedge clk); enableReq = 1'b0;
  endtask
  task automatic doDisable();
    disableReq = 1'b1; @(negedge clk); disableReq = 1'b0;
  endtask
  task automatic doPeer();
    peerStart = 1'b1; @(negedge clk); peerStart = 1'b0;
  endtask
  task automatic doCmp();
    cmpMatch = 1'b1; @(negedge clk); cmpMatch = 1'b0;
  endtask
  task automatic doEnd();
    frameEnd = 1'b1; @(negedge clk); frameEnd = 1'b0;
  endtask

  task automatic finishRun();
    check(expCyc.size() == 0, "R2 missing expected start pulses", expCyc.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    check(startPulse == 1'b0, "R1 startPulse after reset", int'(startPulse), 0);
    check(frameActive == 1'b0, "R1 frameActive after reset", int'(frameActive), 0);
    check(periodTick == 1'b0, "R1 periodTick after reset", int'(periodTick), 0);

    // R2 continuous mode, R13 pulse width
    startMode = 4'd0; startDelay = 8'd0;
    expectIn(2, "R2 continuous start after enable");
    doEnable();
    waitCyc(2);
    check(startPulse == 1'b0, "R13 pulse lasts one cycle", int'(startPulse), 0);
    check(frameActive == 1'b1, "R2 frame active", int'(frameActive), 1);
    expectIn(1, "R2 back-to-back frame");
    doEnd();
    waitCyc(1);
    check(frameActive == 1'b1, "R2 active across back-to-back", int'(frameActive), 1);
    doDisable();
    check(frameActive == 1'b0, "R11 disable drops frame", int'(frameActive), 0);
    waitCyc(3);

    // R3 peer start, R9 ignore while active, R8 delay
    startMode = 4'd1;
    doEnable();
    waitCyc(3);
    check(frameActive == 1'b0, "R3 no start without peer", int'(frameActive), 0);
    expectIn(1, "R3 peer start");
    doPeer();
    waitCyc(2);
    doPeer();  // R9 ignored while active
    waitCyc(3);
    check(frameActive == 1'b1, "R9 active held", int'(frameActive), 1);
    doEnd();
    waitCyc(2);
    check(frameActive == 1'b0, "R9 frame ended", int'(frameActive), 0);
    startDelay = 8'd5;
    expectIn(6, "R8 peer start with delay 5");
    doPeer();
    waitCyc(10);
    doDisable();
    startDelay = 8'd0;
    waitCyc(3);

    // R4 level modes
    syncIn = 1'b1;
    startMode = 4'd2;
    waitCyc(4);
    doEnable();
    waitCyc(4);
    check(frameActive == 1'b0, "R4 low mode idle while line high", int'(frameActive), 0);
    expectIn(3, "R4 low level start");
    syncIn = 1'b0;
    waitCyc(5);
    doDisable();
    startMode = 4'd3;
    waitCyc(3);
    doEnable();
    waitCyc(4);
    check(frameActive == 1'b0, "R4 high mode idle while line low", int'(frameActive), 0);
    expectIn(3, "R4 high level start");
    syncIn = 1'b1;
    waitCyc(5);
    doDisable();
    waitCyc(3);

    // R5 edge modes
    startMode = 4'd4;
    doEnable();
    waitCyc(4);
    check(frameActive == 1'b0, "R5 no start on steady high", int'(frameActive), 0);
    expectIn(3, "R5 falling edge start");
    syncIn = 1'b0;
    waitCyc(5);
    doEnd();
    syncIn = 1'b1;  // rising edge, ignored in falling mode
    waitCyc(5);
    check(frameActive == 1'b0, "R5 rising edge ignored", int'(frameActive), 0);
    startMode = 4'd5;
    syncIn = 1'b0;
    waitCyc(4);
    check(frameActive == 1'b0, "R5 falling edge ignored", int'(frameActive), 0);
    expectIn(3, "R5 rising edge start");
    syncIn = 1'b1;
    waitCyc(5);
    syncIn = 1'b0;
    waitCyc(3);
    syncIn = 1'b1;  // R9 edge during frame
    waitCyc(4);
    check(frameActive == 1'b1, "R9 edge during frame ignored", int'(frameActive), 1);
    doEnd();
    waitCyc(5);
    check(frameActive == 1'b0, "R9 no late start after frame", int'(frameActive), 0);
    doDisable();
    waitCyc(3);

    // R6 level change mode
    startMode = 4'd6;
    doEnable();
    waitCyc(3);
    check(frameActive == 1'b0, "R6 no change no start", int'(frameActive), 0);
    expectIn(3, "R6 level change start");
    syncIn = 1'b0;
    waitCyc(5);
    syncIn = 1'b1;
    waitCyc(4);
    expectIn(2, "R6 pending change starts after frame end");
    doEnd();
    waitCyc(5);
    check(frameActive == 1'b1, "R6 restarted", int'(frameActive), 1);
    doDisable();
    waitCyc(3);

    // R6 any-edge mode loses a change made during a frame
    startMode = 4'd7;
    doEnable();
    waitCyc(3);
    expectIn(3, "R6 edge mode start");
    syncIn = 1'b0;
    waitCyc(5);
    syncIn = 1'b1;
    waitCyc(4);
    doEnd();
    waitCyc(6);
    check(frameActive == 1'b0, "R6 edge mode no restart", int'(frameActive), 0);
    doDisable();
    waitCyc(3);

    // R7 compare start with delay 2 (R8)
    startMode = 4'd8; startDelay = 8'd2;
    doEnable();
    waitCyc(2);
    doPeer();
    waitCyc(4);
    check(frameActive == 1'b0, "R7 peer ignored in compare mode", int'(frameActive), 0);
    expectIn(3, "R7 compare start with delay 2");
    doCmp();
    waitCyc(5);
    check(frameActive == 1'b1, "R7 frame active", int'(frameActive), 1);
    doDisable();
    startDelay = 8'd0;
    waitCyc(3);

    // R10 unused codes
    for (int md = 9; md < 16; md++) begin
      startMode = 4'(md);
      doEnable();
      syncIn = ~syncIn;
      waitCyc(4);
      syncIn = ~syncIn;
      doPeer();
      doCmp();
      waitCyc(5);
      check(frameActive == 1'b0, "R10 unused code never starts", md, 0);
      doDisable();
      waitCyc(2);
    end

    // R11 disable cancels a pending delayed start
    startMode = 4'd1; startDelay = 8'd20;
    doEnable();
    doPeer();
    waitCyc(5);
    doDisable();
    waitCyc(30);
    check(frameActive == 1'b0, "R11 pending start cancelled", int'(frameActive), 0);
    // R11 disable wins over enable
    startMode = 4'd0; startDelay = 8'd0;
    enableReq = 1'b1; disableReq = 1'b1;
    waitCyc(1);
    enableReq = 1'b0; disableReq = 1'b0;
    waitCyc(4);
    check(frameActive == 1'b0, "R11 disable wins over enable", int'(frameActive), 0);
    // R11 conditions while disabled are not remembered
    startMode = 4'd1;
    doPeer();
    doEnable();
    waitCyc(5);
    check(frameActive == 1'b0, "R11 peer while disabled ignored", int'(frameActive), 0);
    doDisable();
    waitCyc(5);

    // R12 period tick
    startMode = 4'd9; periodSel = 8'd1;
    waitCyc(3);
    tickLog.delete();
    begin
      int n0;
      n0 = cyc;
      doEnable();
      waitCyc(11);
      check(tickLog.size() >= 2, "R12 tick count", tickLog.size(), 2);
      if (tickLog.size() >= 2) begin
        check(tickLog[0] == n0 + 5, "R12 first tick", tickLog[0], n0 + 5);
        check(tickLog[1] == n0 + 9, "R12 tick spacing", tickLog[1], n0 + 9);
      end
    end
    doDisable();
    periodSel = 8'd0;
    waitCyc(4);
    tickLog.delete();
    doEnable();
    waitCyc(20);
    check(tickLog.size() == 0, "R12 no tick with period 0", tickLog.size(), 0);
    doDisable();
    waitCyc(4);

    finishRun();
  end

endmodule